// File: doc/BRIEF.md
# Transfer Descriptor Completion and Skip Tracker

This block sits beside a host-controller engine that works through a buffer of up to 32 asynchronous transfer descriptors. It keeps two 32-bit masks, with bit i standing for the i-th descriptor in the buffer and bit 0 for the first. The first is a skip mask that software writes. The second is a completion map: hardware sets its bits and software clears them by reading the map. A 10-bit block-size value for the buffer is kept as well and driven to the engine.

Software reaches the registers through a 16-bit port. A command strobe carries an 8-bit code that selects a register and a direction. Each write code is the matching read code with bit 7 set. Data strobes then move 16-bit words, and a 32-bit register takes two words with the low word first. The engine reports each finished descriptor with a completion strobe that carries the index and the handshake result. From the skip mask and an active-descriptor count, the block gives the engine the index of the next eligible descriptor in round-robin order, or a flag that says no descriptor is eligible.

Top module: `td_tracker`

## Requirements
- R1: After reset the skip mask, the completion map and the block size are all zero. With every descriptor active, the offered index is 0 and the none flag is low.
- R2: A completion strobe with `cpl_ack`=1 and index i sets bit i of the completion map at the clock edge where the strobe is sampled. Bits that are already set stay set.
- R3: A completion strobe with `cpl_ack`=0 leaves the completion map unchanged.
- R4: Code 0x1B reads the completion map as two words, bits 15:0 and then bits 31:16. The edge that takes the second word clears every bit that was reported. When no completion coincides, the map reads zero afterwards.
- R5: A completion that coincides with either word of a map read is left out of the value returned. It stays set after the clear and appears in the next read.
- R6: Code 0x9C writes the skip mask as two words, low word first. Code 0x1C reads it back in the same order.
- R7: Code 0xD4 writes the block size from `dat_in[9:0]`, and `blk_size` drives that value. Code 0x54 reads it back with bits 15:10 as zero.
- R8: The offered index is never a descriptor whose skip bit is 1. The scan starts at the index just after the last one taken with `sel_take` and wraps from 31 to 0. Clearing a skip bit makes that descriptor eligible again.
- R9: Only indices below `active_cnt` (0 to 32) are offered. `sel_none` is 1 exactly when no index below `active_cnt` has a skip bit of 0.
- R10: Codes other than the five above return 0 on `rd_data` and ignore writes. A data write made while a read code is selected changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command strobe; loads `cmd_code` and restarts at word 0 |
| cmd_code | input | 8 | Register select and direction code |
| dat_wr | input | 1 | Write-word strobe |
| dat_in | input | 16 | Write data word |
| dat_rd | input | 1 | Read-word strobe; `rd_data` is valid in the same cycle |
| rd_data | output | 16 | Current word of the selected read register |
| cpl_valid | input | 1 | Descriptor completion strobe from the engine |
| cpl_idx | input | 5 | Index of the completed descriptor |
| cpl_ack | input | 1 | 1 when the device returned an acknowledge |
| active_cnt | input | 6 | Number of descriptors in use, 0 to 32 |
| sel_take | input | 1 | Engine takes the offered index |
| sel_idx | output | 5 | Next eligible descriptor index |
| sel_none | output | 1 | No descriptor is eligible |
| blk_size | output | 10 | Buffer block size |

## Verification
The completion map is tried with one acknowledged completion at each of the 32 indices. This shows whether bit placement, word order and the clear after the second word are right at every position. A full sweep of rejected handshakes separates the acknowledge qualifier from a plain strobe. Completions placed on the first and on the second read word test whether a new bit is lost or leaks into the returned value. For the selector, several skip masks (empty, alternating, all but one, all set, both ends) are combined with active counts of 1, 5, 17 and 32. Each combination is followed by a run of takes, so wrap-around, the count limit and changes of the skip mask while the selector runs are all compared against a round-robin model in the bench.

// File: rtl/td_pkg.sv
`timescale 1ns/1ps
package td_pkg;

    localparam logic [7:0] CODE_DONE_RD = 8'h1B;
    localparam logic [7:0] CODE_SKIP_RD = 8'h1C;
    localparam logic [7:0] CODE_BLK_RD  = 8'h54;
    localparam logic [7:0] CODE_WR_BIT  = 8'h80;

    typedef enum logic [2:0] {
        SEL_NONE    = 3'd0,
        SEL_DONE_RD = 3'd1,
        SEL_SKIP_RD = 3'd2,
        SEL_SKIP_WR = 3'd3,
        SEL_BLK_RD  = 3'd4,
        SEL_BLK_WR  = 3'd5
    } reg_sel_e;

    function automatic reg_sel_e decode_code(input logic [7:0] code);
        reg_sel_e r;
        case (code)
            CODE_DONE_RD:               r = SEL_DONE_RD;
            CODE_SKIP_RD:               r = SEL_SKIP_RD;
            CODE_SKIP_RD | CODE_WR_BIT: r = SEL_SKIP_WR;
            CODE_BLK_RD:                r = SEL_BLK_RD;
            CODE_BLK_RD | CODE_WR_BIT:  r = SEL_BLK_WR;
            default:                    r = SEL_NONE;
        endcase
        return r;
    endfunction

    function automatic logic is_read_sel(input reg_sel_e s);
        return (s == SEL_DONE_RD) || (s == SEL_SKIP_RD) || (s == SEL_BLK_RD);
    endfunction

    function automatic logic is_write_sel(input reg_sel_e s);
        return (s == SEL_SKIP_WR) || (s == SEL_BLK_WR);
    endfunction

endpackage

// File: rtl/td_cmd_port.sv
`timescale 1ns/1ps
module td_cmd_port
    import td_pkg::*;
#(
    parameter int WORDS = 2,
    localparam int WW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_we,
    input  logic [7:0]    cmd_code,
    input  logic          dat_rd,
    input  logic          dat_wr,
    output reg_sel_e      sel,
    output logic [WW-1:0] word,
    output logic          rd_fire,
    output logic          wr_fire
);

    typedef struct packed {
        reg_sel_e      sel;
        logic [WW-1:0] word;
    } port_state_t;

    port_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        rd_fire = !cmd_we && dat_rd && is_read_sel(st_q.sel);
        wr_fire = !cmd_we && dat_wr && is_write_sel(st_q.sel);
        if (cmd_we) begin
            st_d.sel  = decode_code(cmd_code);
            st_d.word = '0;
        end else if (rd_fire || wr_fire) begin
            if (int'(st_q.word) == WORDS - 1)
                st_d.word = '0;
            else
                st_d.word = st_q.word + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sel  <= SEL_NONE;
            st_q.word <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel  = st_q.sel;
    assign word = st_q.word;

endmodule

// File: rtl/td_done_map.sv
`timescale 1ns/1ps
module td_done_map #(
    parameter int N  = 32,
    parameter int DW = 16,
    localparam int WORDS = N / DW,
    localparam int WW = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpl_valid,
    input  logic          cpl_ack,
    input  logic [IW-1:0] cpl_idx,
    input  logic          rd_fire,
    input  logic [WW-1:0] word,
    output logic [N-1:0]  done_map,
    output logic [DW-1:0] rd_word
);

    typedef struct packed {
        logic [N-1:0] done;
        logic [N-1:0] snap;
    } done_state_t;

    done_state_t st_d, st_q;
    logic [N-1:0] set_vec;
    logic [N-1:0] clr_mask;
    int           base;

    always_comb begin
        set_vec  = '0;
        if (cpl_valid && cpl_ack)
            set_vec = {{(N-1){1'b0}}, 1'b1} << cpl_idx;
        clr_mask = (WORDS == 1) ? st_q.done : st_q.snap;
        base     = int'(word) * DW;
        rd_word  = (word == '0) ? st_q.done[base +: DW] : st_q.snap[base +: DW];

        st_d      = st_q;
        st_d.done = st_q.done | set_vec;
        if (rd_fire && word == '0)
            st_d.snap = st_q.done;
        if (rd_fire && int'(word) == WORDS - 1)
            st_d.done = (st_q.done & ~clr_mask) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.done <= '0;
            st_q.snap <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_map = st_q.done;

endmodule

// File: rtl/td_rr_select.sv
`timescale 1ns/1ps
module td_rr_select #(
    parameter int N = 32,
    localparam int IW = $clog2(N),
    localparam int AW = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  skip,
    input  logic [AW-1:0] active_cnt,
    input  logic          take,
    output logic [IW-1:0] pick_idx,
    output logic          pick_none
);

    typedef struct packed {
        logic [IW-1:0] last;
    } rr_state_t;

    rr_state_t    st_d, st_q;
    logic [N-1:0] elig;
    logic         found;
    int           cand;

    for (genvar g = 0; g < N; g++) begin : g_elig
        assign elig[g] = !skip[g] && (active_cnt > AW'(g));
    end

    always_comb begin
        found    = 1'b0;
        pick_idx = '0;
        cand     = 0;
        for (int k = 1; k <= N; k++) begin
            cand = (int'(st_q.last) + k) % N;
            if (!found && elig[cand]) begin
                found    = 1'b1;
                pick_idx = IW'(cand);
            end
        end
        pick_none = !found;

        st_d = st_q;
        if (take && found)
            st_d.last = pick_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q.last <= IW'(N - 1);
        else
            st_q <= st_d;
    end

endmodule

// File: rtl/td_tracker.sv
`timescale 1ns/1ps
module td_tracker
    import td_pkg::*;
#(
    parameter int N  = 32,
    parameter int DW = 16,
    parameter int BW = 10,
    localparam int WORDS = N / DW,
    localparam int WW = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int IW = $clog2(N),
    localparam int AW = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_we,
    input  logic [7:0]    cmd_code,
    input  logic          dat_wr,
    input  logic [DW-1:0] dat_in,
    input  logic          dat_rd,
    output logic [DW-1:0] rd_data,
    input  logic          cpl_valid,
    input  logic [IW-1:0] cpl_idx,
    input  logic          cpl_ack,
    input  logic [AW-1:0] active_cnt,
    input  logic          sel_take,
    output logic [IW-1:0] sel_idx,
    output logic          sel_none,
    output logic [BW-1:0] blk_size
);

    typedef struct packed {
        logic [N-1:0]  skip;
        logic [BW-1:0] blk;
    } cfg_state_t;

    cfg_state_t    st_d, st_q;
    reg_sel_e      cur_sel;
    logic [WW-1:0] cur_word;
    logic          rd_fire;
    logic          wr_fire;
    logic [N-1:0]  done_map;
    logic [DW-1:0] done_word;
    logic [N-1:0]  skip_mask;
    int            wbase;

    td_cmd_port #(.WORDS(WORDS)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_we   (cmd_we),
        .cmd_code (cmd_code),
        .dat_rd   (dat_rd),
        .dat_wr   (dat_wr),
        .sel      (cur_sel),
        .word     (cur_word),
        .rd_fire  (rd_fire),
        .wr_fire  (wr_fire)
    );

    td_done_map #(.N(N), .DW(DW)) u_done (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpl_valid (cpl_valid),
        .cpl_ack   (cpl_ack),
        .cpl_idx   (cpl_idx),
        .rd_fire   (rd_fire && cur_sel == SEL_DONE_RD),
        .word      (cur_word),
        .done_map  (done_map),
        .rd_word   (done_word)
    );

    td_rr_select #(.N(N)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .skip       (st_q.skip),
        .active_cnt (active_cnt),
        .take       (sel_take),
        .pick_idx   (sel_idx),
        .pick_none  (sel_none)
    );

    always_comb begin
        wbase = int'(cur_word) * DW;
        st_d  = st_q;
        if (wr_fire && cur_sel == SEL_SKIP_WR)
            st_d.skip[wbase +: DW] = dat_in;
        if (wr_fire && cur_sel == SEL_BLK_WR)
            st_d.blk = dat_in[BW-1:0];

        case (cur_sel)
            SEL_DONE_RD: rd_data = done_word;
            SEL_SKIP_RD: rd_data = st_q.skip[wbase +: DW];
            SEL_BLK_RD:  rd_data = DW'(st_q.blk);
            default:     rd_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.skip <= '0;
            st_q.blk  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign skip_mask = st_q.skip;
    assign blk_size  = st_q.blk;

endmodule

// File: rtl/td_tracker_chk.sv
`timescale 1ns/1ps
module td_tracker_chk #(
    parameter int N  = 32,
    parameter int BW = 10,
    localparam int IW = $clog2(N),
    localparam int AW = IW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dat_rd,
    input logic          dat_wr,
    input logic          cpl_valid,
    input logic [IW-1:0] cpl_idx,
    input logic          cpl_ack,
    input logic [AW-1:0] active_cnt,
    input logic [IW-1:0] sel_idx,
    input logic          sel_none,
    input logic [BW-1:0] blk_size,
    input logic [N-1:0]  done_map,
    input logic [N-1:0]  skip_mask
);

    logic [N-1:0] in_range;
    always_comb begin
        for (int i = 0; i < N; i++)
            in_range[i] = (i < int'(active_cnt));
    end

    // R2: an acknowledged completion lands in the map
    a_r2_ack_sets: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid && cpl_ack |=> done_map[$past(cpl_idx)]);

    // R3: a rejected handshake alters nothing when no read is under way
    a_r3_nak_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid && !cpl_ack && !dat_rd |=> done_map == $past(done_map));

    // R4: map bits only drop on a read
    a_r4_clear_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_rd |=> ($past(done_map) & ~done_map) == '0);

    // R6: skip mask only moves on a data write
    a_r6_skip_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_wr |=> $stable(skip_mask));

    // R7: block size only moves on a data write
    a_r7_blk_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_wr |=> $stable(blk_size));

    // R8: offered index is not skipped and within range
    a_r8_pick_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_none |-> !skip_mask[sel_idx] && (AW'(sel_idx) < active_cnt));

    // R9: none flag only when no candidate exists
    a_r9_none_empty: assert property (@(posedge clk) disable iff (!rst_n)
        sel_none |-> $countones(~skip_mask & in_range) == 0);

endmodule

bind td_tracker td_tracker_chk #(.N(N), .BW(BW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .dat_rd     (dat_rd),
    .dat_wr     (dat_wr),
    .cpl_valid  (cpl_valid),
    .cpl_idx    (cpl_idx),
    .cpl_ack    (cpl_ack),
    .active_cnt (active_cnt),
    .sel_idx    (sel_idx),
    .sel_none   (sel_none),
    .blk_size   (blk_size),
    .done_map   (done_map),
    .skip_mask  (skip_mask)
);

// File: tb/td_tracker_tb_top.sv
`timescale 1ns/1ps
module td_tracker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [7:0]  cmd_code = '0;
    logic        dat_wr = 1'b0;
    logic [15:0] dat_in = '0;
    logic        dat_rd = 1'b0;
    logic [15:0] rd_data;
    logic        cpl_valid = 1'b0;
    logic [4:0]  cpl_idx = '0;
    logic        cpl_ack = 1'b0;
    logic [5:0]  active_cnt = 6'd32;
    logic        sel_take = 1'b0;
    logic [4:0]  sel_idx;
    logic        sel_none;
    logic [9:0]  blk_size;

    int checks = 0;
    int failures = 0;
    int model_last = 31;

    always #4 clk = ~clk;

    td_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(cmd_code),
        .dat_wr(dat_wr), .dat_in(dat_in), .dat_rd(dat_rd), .rd_data(rd_data),
        .cpl_valid(cpl_valid), .cpl_idx(cpl_idx), .cpl_ack(cpl_ack),
        .active_cnt(active_cnt), .sel_take(sel_take), .sel_idx(sel_idx),
        .sel_none(sel_none), .blk_size(blk_size)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic [7:0] c);
        cmd_we = 1'b1; cmd_code = c;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic rd_word(output logic [15:0] w);
        dat_rd = 1'b1;
        #1 w = rd_data;
        @(negedge clk);
        dat_rd = 1'b0;
    endtask

    task automatic wr_word(input logic [15:0] w);
        dat_wr = 1'b1; dat_in = w;
        @(negedge clk);
        dat_wr = 1'b0;
    endtask

    task automatic rd32(input logic [7:0] c, output logic [31:0] v);
        logic [15:0] lo, hi;
        cmd(c);
        rd_word(lo);
        rd_word(hi);
        v = {hi, lo};
    endtask

    task automatic wr_skip(input logic [31:0] v);
        cmd(8'h9C);
        wr_word(v[15:0]);
        wr_word(v[31:16]);
    endtask

    task automatic complete(input int idx, input logic ack);
        cpl_valid = 1'b1; cpl_idx = 5'(idx); cpl_ack = ack;
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    function automatic int model_pick(input logic [31:0] skp, input int act, input int last);
        for (int k = 1; k <= 32; k++) begin
            int c;
            c = (last + k) % 32;
            if (c < act && !skp[c]) return c;
        end
        return -1;
    endfunction

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [15:0] w, w0, w1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        check("R1 sel_idx", 32'(sel_idx), 32'd0);
        check("R1 sel_none", 32'(sel_none), 32'd0);
        check("R1 blk_size", 32'(blk_size), 32'd0);
        rd32(8'h1B, v); check("R1 done", v, 32'd0);
        rd32(8'h1C, v); check("R1 skip", v, 32'd0);
        cmd(8'h54); rd_word(w); check("R1 blk read", 32'(w), 32'd0);

        // R2 R4 one acknowledged completion per index
        for (int i = 0; i < 32; i++) begin
            complete(i, 1'b1);
            rd32(8'h1B, v);
            check("R2 R4 single bit", v, 32'h1 << i);
            rd32(8'h1B, v);
            check("R4 cleared", v, 32'd0);
        end
        // R2 accumulation
        complete(0, 1'b1); complete(15, 1'b1); complete(16, 1'b1); complete(31, 1'b1);
        complete(15, 1'b1);
        rd32(8'h1B, v);
        check("R2 accumulate", v, 32'h8001_8001);

        // R3 rejected handshakes
        for (int i = 0; i < 32; i++) complete(i, 1'b0);
        rd32(8'h1B, v);
        check("R3 nak ignored", v, 32'd0);
        complete(7, 1'b1); complete(7, 1'b0); complete(9, 1'b0);
        rd32(8'h1B, v);
        check("R3 nak keeps bit", v, 32'h80);

        // R5 completion on second word of a read
        complete(3, 1'b1);
        cmd(8'h1B);
        rd_word(w0);
        dat_rd = 1'b1; cpl_valid = 1'b1; cpl_idx = 5'd20; cpl_ack = 1'b1;
        #1 w1 = rd_data;
        @(negedge clk);
        dat_rd = 1'b0; cpl_valid = 1'b0;
        check("R5 second-word read", {w1, w0}, 32'h8);
        rd32(8'h1B, v);
        check("R5 kept after clear", v, 32'h1 << 20);
        // R5 completion on first word of a read
        cmd(8'h1B);
        dat_rd = 1'b1; cpl_valid = 1'b1; cpl_idx = 5'd5; cpl_ack = 1'b1;
        #1 w0 = rd_data;
        @(negedge clk);
        cpl_valid = 1'b0; dat_rd = 1'b0;
        rd_word(w1);
        check("R5 first-word read", {w1, w0}, 32'd0);
        rd32(8'h1B, v);
        check("R5 kept first-word", v, 32'h20);

        // R6 skip mask
        wr_skip(32'hA5C3_3C5A);
        rd32(8'h1C, v);
        check("R6 skip readback", v, 32'hA5C3_3C5A);
        wr_skip(32'h0000_0000);
        rd32(8'h1C, v);
        check("R6 skip zero", v, 32'd0);

        // R7 block size
        cmd(8'hD4); wr_word(16'hFFFF);
        #1 check("R7 blk_size out", 32'(blk_size), 32'h3FF);
        cmd(8'h54); rd_word(w);
        check("R7 blk upper zero", 32'(w), 32'h3FF);
        cmd(8'hD4); wr_word(16'h0155);
        cmd(8'h54); rd_word(w);
        check("R7 blk value", 32'(w), 32'h155);

        // R10 ignored codes
        cmd(8'h1C); wr_word(16'hFFFF); wr_word(16'hFFFF);
        rd32(8'h1C, v);
        check("R10 write under read code", v, 32'd0);
        cmd(8'h54); wr_word(16'h0001);
        #1 check("R10 blk unchanged", 32'(blk_size), 32'h155);
        cmd(8'h77); rd_word(w);
        check("R10 unknown code read", 32'(w), 32'd0);
        complete(2, 1'b1);
        cmd(8'h9B); rd_word(w); check("R10 9B read zero", 32'(w), 32'd0);
        wr_word(16'h0000);
        rd32(8'h1B, v);
        check("R10 done untouched", v, 32'h4);

        // R8 R9 selector sweep
        for (int p = 0; p < 5; p++) begin
            logic [31:0] skp;
            case (p)
                0: skp = 32'h0000_0000;
                1: skp = 32'h5555_5555;
                2: skp = 32'hFFFF_FFFE;
                3: skp = 32'hFFFF_FFFF;
                default: skp = 32'h8000_0001;
            endcase
            wr_skip(skp);
            for (int a = 0; a < 4; a++) begin
                int act;
                act = (a == 0) ? 1 : (a == 1) ? 5 : (a == 2) ? 17 : 32;
                active_cnt = 6'(act);
                for (int t = 0; t < 40; t++) begin
                    int e;
                    #1;
                    e = model_pick(skp, act, model_last);
                    if (e < 0) begin
                        check("R9 none flag", 32'(sel_none), 32'd1);
                    end else begin
                        check("R9 none low", 32'(sel_none), 32'd0);
                        check("R8 R9 pick", 32'(sel_idx), 32'(e));
                        model_last = e;
                    end
                    sel_take = 1'b1;
                    @(negedge clk);
                    sel_take = 1'b0;
                end
            end
        end
        // R9 zero active count
        active_cnt = 6'd0;
        #1 check("R9 zero active", 32'(sel_none), 32'd1);
        // R8 clearing a skip bit revives the descriptor
        active_cnt = 6'd32;
        wr_skip(32'hFFFF_FFFF);
        #1 check("R8 all skipped", 32'(sel_none), 32'd1);
        wr_skip(32'hFFFF_DFFF);
        #1 check("R8 revived", 32'(sel_idx), 32'd13);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule